// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 262,144 bytes. The host raises a one-cycle request that carries an 18-bit byte address, a read/write flag and 8 bits of write data. The sequencer turns that request into a timed sequence on the memory strobes. The strobes are a pair of chip selects of opposite polarity, an active-low output enable and an active-low write enable. When the access completes, the sequencer returns a one-cycle acknowledge, together with read data when the access was a read.

Each minimum interval of the memory is a nanosecond parameter. The sequencer converts it into clock cycles by ceiling division with the clock period, and never uses fewer than one cycle. Writes are controlled by the write enable. Both selects go active one cycle before the write strobe falls and stay active for one cycle after it rises. The output enable stays inactive for the whole write. The data bus uses a separate output-enable line. The sequencer drives the bus only after the memory's output has had time to float.

Top module: `sram_async_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, both selects are inactive (`mem_cs_n`=1, `mem_cs`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_drive`=0 and `host_ack`=0.
- R2: The two selects always show the same state. `mem_cs_n` is low exactly when `mem_cs` is high, and that happens only while an access is in progress.
- R3: During a write `mem_oe_n` stays 1. The selects go active one cycle before `mem_we_n` falls and stay active for one cycle after `mem_we_n` rises.
- R4: During a write, `mem_we_n` is low for max(ceil(60/P), D + ceil(30/P)) consecutive cycles, where P is the clock period in ns and D is the turnaround of R5. This is 9 cycles at 8 ns.
- R5: `mem_dq_drive` rises D = max(ceil(33/P), ceil(25/P)) cycles after `mem_we_n` falls (5 cycles at 8 ns). It is never high while `mem_oe_n` is 0.
- R6: The write data stays on `mem_dq_out`, with the drive enabled, up to the cycle in which `mem_we_n` rises and through the following hold cycle. The memory therefore stores the host byte.
- R7: During a read, the selects and `mem_oe_n` are active for ceil(70/P) cycles (9 at 8 ns), `mem_we_n` stays 1, and `mem_addr` does not change.
- R8: `host_rdata` holds the memory byte sampled in the last active read cycle. It is valid in the same cycle as `host_ack`.
- R9: `host_ack` is high for exactly one cycle, the first idle cycle after an access. A request raised while an access is in progress is ignored.
- R10: A request is accepted in any idle cycle, including the acknowledge cycle. `mem_addr` and the write data are captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, sampled when idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Byte address |
| host_wdata | input | 8 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read data, valid with acknowledge |
| mem_addr | output | 18 | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_drive | output | 1 | Enable of the data bus driver |
| mem_dq_in | input | 8 | Data returned by memory |

## Verification
The bench drives a write right after a read. The bus turnaround then matters: a design that drives data too early shows the drive enable high while the output enable is still low, or inside the float window after the write strobe falls. The bench measures the write strobe width and the hold cycle. A short pulse, or data dropped before the strobe rises, makes a read-back mismatch in the bench's pin-level memory. The bench raises requests while an access is in progress and checks that they are ignored. It also issues each new request in the acknowledge cycle. A design that accepted requests early, or that lost the back-to-back acceptance, drifts from the cycle model at once. The bench also uses the extreme addresses and the all-zero and all-one data bytes.

// File: rtl/sram_async_seq_pkg.sv
package sram_async_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WSETUP,
    SQ_WPULSE,
    SQ_WHOLD,
    SQ_RACC
  } seq_state_e;

  // internal strobe intent, active high
  typedef struct packed {
    logic sel;
    logic rd_en;
    logic wr_en;
    logic drive;
    logic done;
  } strobe_ctl_s;

  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_async_seq_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 9,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 9,
  parameter int DRV_WAIT  = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        req_wr,
  output strobe_ctl_s ctl_nxt,
  output logic        accept,
  output logic        capture
);

  localparam int MAXC  = imax(imax(SETUP_CYC, WE_CYC), imax(HOLD_CYC, RD_CYC));
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LAST_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_WE    = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_RD    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_START  = CNT_W'(DRV_WAIT);

  seq_state_e       st, nst;
  logic [CNT_W-1:0] cnt, ncnt;
  logic             fin;

  always_comb begin
    nst     = st;
    ncnt    = cnt + 1'b1;
    accept  = 1'b0;
    capture = 1'b0;
    fin     = 1'b0;
    unique case (st)
      SQ_IDLE: begin
        ncnt = '0;
        if (req) begin
          accept = 1'b1;
          nst    = req_wr ? SQ_WSETUP : SQ_RACC;
        end
      end
      SQ_WSETUP: if (cnt == LAST_SETUP) begin nst = SQ_WPULSE; ncnt = '0; end
      SQ_WPULSE: if (cnt == LAST_WE)    begin nst = SQ_WHOLD;  ncnt = '0; end
      SQ_WHOLD:  if (cnt == LAST_HOLD)  begin nst = SQ_IDLE;   ncnt = '0; fin = 1'b1; end
      SQ_RACC:   if (cnt == LAST_RD) begin
        nst     = SQ_IDLE;
        ncnt    = '0;
        fin     = 1'b1;
        capture = 1'b1;
      end
      default: begin nst = SQ_IDLE; ncnt = '0; end
    endcase
  end

  always_comb begin
    ctl_nxt.sel   = (nst != SQ_IDLE);
    ctl_nxt.rd_en = (nst == SQ_RACC);
    ctl_nxt.wr_en = (nst == SQ_WPULSE);
    ctl_nxt.drive = ((nst == SQ_WPULSE) && (ncnt >= DRV_START)) || (nst == SQ_WHOLD);
    ctl_nxt.done  = fin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      st  <= nst;
      cnt <= ncnt;
    end
  end

  // R9: a new access only starts from idle
  assert_accept_idle_R9: assert property (@(posedge clk) disable iff (rst)
    accept |-> (st == SQ_IDLE));

  // R8: read data is captured only at the end of a read
  assert_capture_read_R8: assert property (@(posedge clk) disable iff (rst)
    capture |-> (st == SQ_RACC));

endmodule

// File: rtl/sram_pin_io.sv
module sram_pin_io
  import sram_async_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_ctl_s       ctl_nxt,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cs_n_q,
  output logic              cs_q,
  output logic              oe_n_q,
  output logic              we_n_q,
  output logic [DATA_W-1:0] dq_out_q,
  output logic              drive_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              ack_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      dq_out_q <= '0;
      rdata_q  <= '0;
      cs_n_q   <= 1'b1;
      cs_q     <= 1'b0;
      oe_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      drive_q  <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      if (accept) begin
        addr_q   <= addr_in;
        dq_out_q <= wdata_in;
      end
      if (capture) rdata_q <= dq_in;
      cs_n_q  <= ~ctl_nxt.sel;
      cs_q    <= ctl_nxt.sel;
      oe_n_q  <= ~ctl_nxt.rd_en;
      we_n_q  <= ~ctl_nxt.wr_en;
      drive_q <= ctl_nxt.drive;
      ack_q   <= ctl_nxt.done;
    end
  end

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (rst)
    drive_q |-> oe_n_q);

  assert_sel_pair_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n_q == ~cs_q);

  assert_oe_off_in_write_R3: assert property (@(posedge clk) disable iff (rst)
    !we_n_q |-> (oe_n_q && !cs_n_q && cs_q));

  assert_sel_before_we_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n_q) |-> $past(!cs_n_q && cs_q));

  assert_hold_after_we_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n_q) |-> (drive_q && !cs_n_q));

  assert_addr_stable_read_R7: assert property (@(posedge clk) disable iff (rst)
    (!oe_n_q && $past(!oe_n_q)) |-> $stable(addr_q));

  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> !ack_q);

endmodule

// File: rtl/sram_async_seq.sv
module sram_async_seq
  import sram_async_seq_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 8,
  parameter int T_CYCLE_NS   = 70,
  parameter int T_ADDR_WE_NS = 65,
  parameter int T_WE_PW_NS   = 60,
  parameter int T_DSU_NS     = 30,
  parameter int T_WE_HZ_NS   = 33,
  parameter int T_OE_HZ_NS   = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_drive,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int DRV_WAIT  = imax(ns_to_cyc(T_WE_HZ_NS, CLK_NS), ns_to_cyc(T_OE_HZ_NS, CLK_NS));
  localparam int WE_CYC    = imax(ns_to_cyc(T_WE_PW_NS, CLK_NS), DRV_WAIT + ns_to_cyc(T_DSU_NS, CLK_NS));
  localparam int SETUP_CYC = imax(1, ns_to_cyc(T_ADDR_WE_NS, CLK_NS) - WE_CYC);
  localparam int HOLD_CYC  = imax(1, ns_to_cyc(T_CYCLE_NS, CLK_NS) - SETUP_CYC - WE_CYC);
  localparam int RD_CYC    = ns_to_cyc(T_CYCLE_NS, CLK_NS);

  strobe_ctl_s ctl_nxt;
  logic        accept;
  logic        capture;

  sram_seq_fsm #(
    .SETUP_CYC(SETUP_CYC),
    .WE_CYC   (WE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .RD_CYC   (RD_CYC),
    .DRV_WAIT (DRV_WAIT)
  ) fsm_i (
    .clk    (clk),
    .rst    (rst),
    .req    (host_req),
    .req_wr (host_wr),
    .ctl_nxt(ctl_nxt),
    .accept (accept),
    .capture(capture)
  );

  sram_pin_io #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) pins_i (
    .clk     (clk),
    .rst     (rst),
    .ctl_nxt (ctl_nxt),
    .accept  (accept),
    .capture (capture),
    .addr_in (host_addr),
    .wdata_in(host_wdata),
    .dq_in   (mem_dq_in),
    .addr_q  (mem_addr),
    .cs_n_q  (mem_cs_n),
    .cs_q    (mem_cs),
    .oe_n_q  (mem_oe_n),
    .we_n_q  (mem_we_n),
    .dq_out_q(mem_dq_out),
    .drive_q (mem_dq_drive),
    .rdata_q (host_rdata),
    .ack_q   (host_ack)
  );

endmodule

// File: tb/sram_async_seq_tb_top.sv
module sram_async_seq_tb_top;

  localparam int WP  = 9;  // R4: max(ceil(60/8)=8, 5+ceil(30/8)=9)
  localparam int DW  = 5;  // R5: max(ceil(33/8)=5, ceil(25/8)=4)
  localparam int RDC = 9;  // R7: ceil(70/8)

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [17:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ack;
  logic [7:0]  host_rdata;
  logic [17:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_drive;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = '0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sram_async_seq dut_i (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive),
    .mem_dq_in(mem_dq_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // pin-level memory: writes latched when the write strobe rises
  logic [7:0] pin_mem [int];
  logic       prev_we = 1'b1;
  int         we_low = 0;

  always @(negedge clk) begin
    if (!rst && prev_we && !mem_we_n) we_low = 0;
    if (!mem_we_n) we_low++;
    if (!rst && !prev_we && mem_we_n) begin
      check("R4 write strobe width", we_low, WP);
      check("R6 drive at strobe rise", mem_dq_drive, 1);
      if (!mem_cs_n && mem_cs) pin_mem[int'(mem_addr)] = mem_dq_out;
    end
    prev_we = mem_we_n;
    if (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n)
      mem_dq_in = pin_mem.exists(int'(mem_addr)) ? pin_mem[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 8'h00;
    if (mem_dq_drive && !mem_oe_n) check("R5 bus contention", 1, 0);
  end

  // behavioural cycle model
  logic [7:0]  ref_mem [int];
  logic        m_busy = 1'b0, m_wr = 1'b0, m_ack = 1'b0, m_was_rd = 1'b0;
  int          m_t = 0;
  logic [17:0] m_addr = '0;
  logic [7:0]  m_data = '0, m_rdata = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 1'b0; m_ack <= 1'b0; m_addr <= '0; m_t <= 0; m_rdata <= '0;
    end else begin
      m_ack <= 1'b0;
      if (!m_busy) begin
        if (host_req) begin
          m_busy <= 1'b1; m_wr <= host_wr; m_t <= 1;
          m_addr <= host_addr; m_data <= host_wdata;
          if (host_wr) ref_mem[int'(host_addr)] = host_wdata;
        end
      end else if ((m_wr && m_t == WP + 2) || (!m_wr && m_t == RDC)) begin
        m_busy <= 1'b0; m_ack <= 1'b1; m_was_rd <= !m_wr;
        if (!m_wr) m_rdata <= ref_mem.exists(int'(m_addr)) ? ref_mem[int'(m_addr)] : 8'h00;
      end else begin
        m_t <= m_t + 1;
      end
    end
  end

  logic compare_on = 1'b0;

  always @(negedge clk) begin
    if (compare_on) begin
      logic e_we, e_drv;
      e_we  = m_busy && m_wr && m_t >= 2 && m_t <= WP + 1;
      e_drv = m_busy && m_wr && ((m_t >= 2 + DW && m_t <= WP + 1) || m_t == WP + 2);
      check("R2 cs_n", mem_cs_n, !m_busy);
      check("R2 cs", mem_cs, m_busy);
      check("R3/R7 oe_n", mem_oe_n, !(m_busy && !m_wr));
      check("R3/R4 we_n", mem_we_n, !e_we);
      check("R5 dq_drive", mem_dq_drive, e_drv);
      check("R10 mem_addr", mem_addr, m_addr);
      if (e_drv) check("R6 dq_out", mem_dq_out, m_data);
      check("R9 host_ack", host_ack, m_ack);
      if (m_ack && m_was_rd) check("R8 host_rdata", host_rdata, m_rdata);
    end
  end

  task automatic access(input logic wr, input logic [17:0] a, input logic [7:0] d, input bit poke);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    if (poke) begin
      // R9: requests while busy must be ignored
      repeat (2) @(negedge clk);
      host_req = 1'b1; host_wr = !wr; host_addr = ~a; host_wdata = ~d;
      repeat (2) @(negedge clk);
      host_req = 1'b0;
    end
    for (int i = 0; i < 40 && !host_ack; i++) @(negedge clk);
    check("R9 ack seen", host_ack, 1);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cs_n in reset", mem_cs_n, 1);
    check("R1 cs in reset", mem_cs, 0);
    check("R1 oe_n in reset", mem_oe_n, 1);
    check("R1 we_n in reset", mem_we_n, 1);
    check("R1 drive in reset", mem_dq_drive, 0);
    check("R1 ack in reset", host_ack, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_drive, host_ack}, 6'b101100);
    compare_on = 1'b1;
    // each new access is issued in the ack cycle (R10 back-to-back)
    access(1'b1, 18'h00000, 8'hA5, 1'b0);
    access(1'b1, 18'h3FFFF, 8'hFF, 1'b1);
    access(1'b0, 18'h00000, 8'h00, 1'b0);
    check("R8 read lowest address", host_rdata, 8'hA5);
    access(1'b1, 18'h12345, 8'h00, 1'b0);
    access(1'b0, 18'h3FFFF, 8'h00, 1'b1);
    check("R8 read highest address", host_rdata, 8'hFF);
    access(1'b0, 18'h12345, 8'h11, 1'b0);
    check("R6 zero byte stored", host_rdata, 8'h00);
    for (int k = 0; k < 8; k++) begin
      access(1'b1, 18'(k * 4099), 8'(8'h3C ^ (k * 37)), k[0]);
      access(1'b0, 18'(k * 4099), 8'h00, 1'b0);
      check("R8 pattern readback", host_rdata, 8'(8'h3C ^ (k * 37)));
    end
    access(1'b0, 18'h2AAAA, 8'h00, 1'b0);
    check("R8 unwritten byte", host_rdata, 8'h00);
    repeat (4) @(negedge clk);
    check("R9 no stray ack", host_ack, 0);
    check("R2 idle deselected", {mem_cs_n, mem_cs}, 2'b10);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule